// File: doc/BRIEF.md
# Quad 8-bit DAC serial command controller

This block is the digital front end of a four-channel, 8-bit voltage DAC. A host writes 12-bit command words over a three-wire serial port made of a serial clock, an active-low select and a data line. The block samples all of its pins with its own system clock. When the select line returns high, the block decodes the last word it received. The word holds a 2-bit channel address, a 2-bit operation field and an 8-bit code. Each channel has an input register and a DAC register, so the four channels form a double-buffered bank. Commands can write the input registers, the DAC registers, or both. Commands can also copy every input register into its DAC register in one step.

Two pins act on the bank without the serial port. The active-low load pin is level-sensitive: while it is low, every DAC register follows its input register. The active-low clear pin zeroes all eight registers at once, without waiting for the clock. A serial output returns the bits that fall out of the shift register, so several devices can be chained. A command selects whether that output changes on the rising or the falling serial clock edge, and the choice stays in force until another command changes it. The only analog-facing output is the four 8-bit DAC register values, packed into one bus.

Top module: `sdac_cmd_ctrl`

## Requirements
- R1: After rst_ni is released, every DAC code is 0x00, dout_o is 0, and the serial output is in rising-edge mode.
- R2: A word is taken most significant bit first, in the order A1 A0 C1 C0 D7..D0. Bits are taken on serial clock rising edges only while cs_ni is low. If more than 12 bits arrive in one frame, only the last 12 are used.
- R3: On the cs_ni rising edge, C1C0=01 writes D into the input register of channel A1A0 (00 is channel 0, 11 is channel 3). No DAC register changes while the load pin is high.
- R4: C1C0=11 writes D into both the input register and the DAC register of channel A1A0.
- R5: C1C0=00 with A1A0=01 writes D into all four DAC registers and leaves the input registers unchanged.
- R6: C1C0=00 with A1A0=00 or 1x changes no input register and no DAC register.
- R7: C1C0=10 with A1A0=1x copies every input register into its DAC register.
- R8: C1C0=10 with A1A0=00 selects falling-edge mode, and with A1A0=01 selects rising-edge mode. Both also perform the copy of R7. The mode holds until the other of these two commands arrives.
- R9: In rising-edge mode, dout_o changes after a serial clock rising edge and shows the bit taken 12 rising edges earlier. While cs_ni is high, dout_o and the shift register do not change.
- R10: In falling-edge mode, dout_o changes after a serial clock falling edge. The bit taken at rising edge k appears after the falling edge that follows rising edge k+12, a lag of 12.5 clocks.
- R11: While ldac_ni is low, each DAC register follows its input register, including any input register written during that time.
- R12: While clr_ni is low, all input and DAC registers are zero, without waiting for a clock edge. Releasing clr_ni leaves them at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all serial and control pins |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sclk_i | input | 1 | Serial clock; idles low |
| cs_ni | input | 1 | Active-low frame select; its rising edge executes the command |
| din_i | input | 1 | Serial data in |
| ldac_ni | input | 1 | Active-low level-sensitive load; DAC registers follow input registers while low |
| clr_ni | input | 1 | Active-low asynchronous clear of all input and DAC registers |
| dout_o | output | 1 | Serial data out for chaining devices |
| dac_code_o | output | 32 | DAC register codes; channel i occupies bits [8i+7:8i] |

## Verification
Two behaviours are hard to observe from the ports. The half-clock extra lag of falling-edge mode can only be seen by sampling dout_o twice per serial clock period, once late in the high phase and once late in the low phase, and by comparing both samples against a running history of every bit sent. The input registers are never visible directly. Their contents after an input-only load, a broadcast or a clear are therefore brought out through a following copy command, and the scoreboard compares the resulting DAC codes.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LOAD_IN   = 3'd1,
    OP_LOAD_BOTH = 3'd2,
    OP_BCAST     = 3'd3,
    OP_COPY      = 3'd4
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] addr;
    logic       set_phase;
    logic       phase_fall;
  } cmd_t;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdac_serial_port.sv
module sdac_serial_port #(
  parameter int unsigned WORD_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  input  logic              fall_mode_i,
  output logic [WORD_W-1:0] word_o,
  output logic              exec_o,
  output logic              dout_o
);

  logic [2:0] pins_s;
  logic sclk_s, cs_s, din_s;
  logic sclk_prev_q, cs_prev_q;
  logic sclk_rise, sclk_fall, cs_lo;
  logic [WORD_W-1:0] sr_q;
  logic out_bit_q, dout_q;

  // all three pins share one synchronizer so their relative timing is kept
  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({din_i, cs_ni, sclk_i}),
    .q_o   (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign cs_s   = pins_s[1];
  assign din_s  = pins_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign cs_lo     = ~cs_s;
  assign exec_o    = cs_s & ~cs_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      out_bit_q <= 1'b0;
    end else if (cs_lo && sclk_rise) begin
      sr_q      <= {sr_q[WORD_W-2:0], din_s};
      out_bit_q <= sr_q[WORD_W-1];
    end
  end

  // rising mode: follow the bit leaving the register; falling mode: half clock later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 1'b0;
    end else if (cs_lo) begin
      if (!fall_mode_i && sclk_rise)     dout_q <= sr_q[WORD_W-1];
      else if (fall_mode_i && sclk_fall) dout_q <= out_bit_q;
    end
  end

  assign word_o = sr_q;
  assign dout_o = dout_q;

  AST_CS_HIGH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_lo |=> $stable(dout_q) && $stable(sr_q)); // R9

  AST_EXEC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o); // R2

endmodule

// File: rtl/sdac_cmd_decode.sv
module sdac_cmd_decode
  import sdac_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WORD_W = DATA_W + 4
) (
  input  logic [WORD_W-1:0] word_i,
  output cmd_t              cmd_o,
  output logic [DATA_W-1:0] data_o
);

  logic [1:0] addr, ctrl;

  assign addr   = word_i[WORD_W-1 -: 2];
  assign ctrl   = word_i[WORD_W-3 -: 2];
  assign data_o = word_i[DATA_W-1:0];

  always_comb begin
    cmd_o            = '0;
    cmd_o.addr       = addr;
    cmd_o.op         = OP_NOP;
    unique case (ctrl)
      2'b01: cmd_o.op = OP_LOAD_IN;
      2'b11: cmd_o.op = OP_LOAD_BOTH;
      2'b00: cmd_o.op = (addr == 2'b01) ? OP_BCAST : OP_NOP;
      2'b10: begin
        cmd_o.op         = OP_COPY;
        cmd_o.set_phase  = ~addr[1];
        cmd_o.phase_fall = (addr == 2'b00);
      end
      default: cmd_o.op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/sdac_reg_bank.sv
module sdac_reg_bank
  import sdac_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     exec_i,
  input  cmd_t                     cmd_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     ldac_lo_i,
  output logic [NUM_CH*DATA_W-1:0] dac_o
);

  logic [DATA_W-1:0] in_q  [NUM_CH];
  logic [DATA_W-1:0] dac_q [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    logic [DATA_W-1:0] in_d, dac_d;

    assign sel = (32'(cmd_i.addr) == i);

    always_comb begin
      in_d  = in_q[i];
      dac_d = dac_q[i];
      if (exec_i) begin
        unique case (cmd_i.op)
          OP_LOAD_IN:   if (sel) in_d = data_i;
          OP_LOAD_BOTH: if (sel) begin
                          in_d  = data_i;
                          dac_d = data_i;
                        end
          OP_BCAST:     dac_d = data_i;
          OP_COPY:      dac_d = in_q[i];
          default:      ;
        endcase
      end
      // transparent load pin: DAC follows the input register's next value
      if (ldac_lo_i) dac_d = in_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q[i]  <= '0;
        dac_q[i] <= '0;
      end else begin
        in_q[i]  <= in_d;
        dac_q[i] <= dac_d;
      end
    end

    assign dac_o[i*DATA_W +: DATA_W] = dac_q[i];

    AST_LDAC_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ldac_lo_i |=> dac_q[i] == in_q[i]); // R11

    AST_NOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exec_i && cmd_i.op == OP_NOP && !ldac_lo_i) |=> $stable(in_q[i]) && $stable(dac_q[i])); // R6

    AST_LOAD_IN_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exec_i && cmd_i.op == OP_LOAD_IN && !ldac_lo_i) |=> $stable(dac_q[i])); // R3

    AST_BCAST_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exec_i && cmd_i.op == OP_BCAST && !ldac_lo_i) |=> dac_q[i] == $past(data_i) && $stable(in_q[i])); // R5
  end

endmodule

// File: rtl/sdac_cmd_ctrl.sv
module sdac_cmd_ctrl
  import sdac_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = DATA_W + 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     cs_ni,
  input  logic                     din_i,
  input  logic                     ldac_ni,
  input  logic                     clr_ni,
  output logic                     dout_o,
  output logic [NUM_CH*DATA_W-1:0] dac_code_o
);

  logic [WORD_W-1:0] word;
  logic              exec;
  cmd_t              cmd;
  logic [DATA_W-1:0] data;
  logic              fall_mode_q;
  logic              ldac_s;
  logic              bank_rst_n;

  sdac_serial_port #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .cs_ni      (cs_ni),
    .din_i      (din_i),
    .fall_mode_i(fall_mode_q),
    .word_o     (word),
    .exec_o     (exec),
    .dout_o     (dout_o)
  );

  sdac_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .word_i(word),
    .cmd_o (cmd),
    .data_o(data)
  );

  sdac_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ldac_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ldac_ni),
    .q_o   (ldac_s)
  );

  // output phase survives the clear pin; only power-on reset restores it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     fall_mode_q <= 1'b0;
    else if (exec && cmd.set_phase)  fall_mode_q <= cmd.phase_fall;
  end

  assign bank_rst_n = rst_ni & clr_ni;

  sdac_reg_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (bank_rst_n),
    .exec_i   (exec),
    .cmd_i    (cmd),
    .data_i   (data),
    .ldac_lo_i(~ldac_s),
    .dac_o    (dac_code_o)
  );

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec && cmd.set_phase) |=> $stable(fall_mode_q)); // R8

  AST_PHASE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && cmd.set_phase) |=> fall_mode_q == $past(cmd.phase_fall)); // R8

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> dac_code_o == '0); // R12

endmodule

// File: tb/tb_sdac_cmd_ctrl.sv
module tb_sdac_cmd_ctrl;

  localparam int HP     = 6;   // system clocks per serial clock half period
  localparam int SETTLE = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic dout;
  logic [31:0] dac_code;

  always #10 clk = ~clk;

  sdac_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .ldac_ni(ldac_n), .clr_ni(clr_n), .dout_o(dout), .dac_code_o(dac_code)
  );

  int checks = 0, errors = 0;
  bit done = 0, chk_dout = 0;

  logic [7:0] in_m [4];
  logic [7:0] dac_m [4];
  bit fall_m = 0, ldac_m = 0;
  logic hist [$];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  event        mon_ev;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dac_vec();
    return {dac_m[3], dac_m[2], dac_m[1], dac_m[0]};
  endfunction

  task automatic expect_dac(input string req);
    exp_q.push_back(dac_vec());
    tag_q.push_back(req);
    -> mon_ev;
    repeat (SETTLE + 4) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(mon_ev);
      repeat (SETTLE) @(negedge clk);
      begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dac_code == e, t, dac_code, e);
      end
    end
  end

  task automatic shift_bit(input logic b);
    logic lo, hi;
    int p;
    din = b;
    hist.push_back(b);
    repeat (HP) @(negedge clk);
    lo = dout;
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
    hi = dout;
    sclk = 1'b0;
    if (chk_dout) begin
      p = hist.size() - 1;
      if (!fall_m) check(hi == hist[p-12], "R9 dout lag 12", 32'(hi), 32'(hist[p-12]));
      else begin
        check(hi == hist[p-13], "R10 dout after rise", 32'(hi), 32'(hist[p-13]));
        check(lo == hist[p-13], "R10 dout after fall", 32'(lo), 32'(hist[p-13]));
      end
    end
  endtask

  task automatic model_apply(input logic [11:0] w);
    logic [1:0] a, c;
    logic [7:0] d;
    a = w[11:10]; c = w[9:8]; d = w[7:0];
    case (c)
      2'b01: in_m[a] = d;
      2'b11: begin in_m[a] = d; dac_m[a] = d; end
      2'b00: if (a == 2'b01) for (int i = 0; i < 4; i++) dac_m[i] = d;
      2'b10: begin
        for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
        if (a == 2'b00) fall_m = 1;
        else if (a == 2'b01) fall_m = 0;
      end
      default: ;
    endcase
    if (ldac_m) for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
  endtask

  task automatic send(input logic [15:0] bits, input int n, input string req);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int k = n - 1; k >= 0; k--) shift_bit(bits[k]);
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    model_apply(bits[11:0]);
    expect_dac(req);
  endtask

  task automatic send_word(input logic [1:0] a, input logic [1:0] c, input logic [7:0] d, input string req);
    send({4'h0, a, c, d}, 12, req);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; dac_m[i] = '0; end
    for (int i = 0; i < 13; i++) hist.push_back(1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check(dac_code == 32'h0, "R1 reset codes", dac_code, 32'h0);
    check(dout == 1'b0, "R1 reset dout", 32'(dout), 32'h0);

    send_word(2'b01, 2'b01, 8'h5A, "R3 load input only");
    send_word(2'b10, 2'b11, 8'hC3, "R4 load input and dac");
    send_word(2'b10, 2'b10, 8'hFF, "R7 software copy");
    send_word(2'b01, 2'b00, 8'h77, "R5 broadcast");
    send_word(2'b11, 2'b10, 8'h00, "R5 inputs kept after broadcast (R7 copy)");
    send_word(2'b00, 2'b00, 8'hFF, "R6 nop a=00");
    send_word(2'b11, 2'b00, 8'h99, "R6 nop a=11");
    send({4'hF, 2'b11, 2'b11, 8'h81}, 16, "R2 16-bit frame uses last 12");

    // serial clock while deselected: nothing shifts, dout holds
    begin
      logic held;
      held = dout;
      for (int k = 0; k < 4; k++) begin
        din = 1'b1; repeat (HP) @(negedge clk);
        sclk = 1'b1; repeat (HP) @(negedge clk);
        sclk = 1'b0;
      end
      check(dout == held, "R9 dout holds with cs high", 32'(dout), 32'(held));
    end
    send_word(2'b00, 2'b00, 8'h00, "R2 cs-high clocks ignored");

    chk_dout = 1;
    send_word(2'b00, 2'b00, 8'hA5, "R9 daisy nop 1");
    send_word(2'b00, 2'b00, 8'h3C, "R9 daisy nop 2");
    send_word(2'b00, 2'b10, 8'h00, "R8 falling mode with copy");
    send_word(2'b00, 2'b00, 8'hC6, "R10 daisy nop 1");
    send_word(2'b11, 2'b10, 8'h5B, "R8 sw load keeps mode");
    send_word(2'b00, 2'b00, 8'h93, "R10 daisy nop 2");
    send_word(2'b01, 2'b10, 8'h00, "R8 rising mode with copy");
    send_word(2'b00, 2'b00, 8'h6E, "R9 daisy after return");
    chk_dout = 0;

    @(negedge clk);
    ldac_n = 1'b0; ldac_m = 1;
    for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
    expect_dac("R11 load pin low");
    send_word(2'b00, 2'b01, 8'h11, "R11 input write passes through");
    ldac_n = 1'b1; ldac_m = 0;
    repeat (4) @(negedge clk);
    send_word(2'b00, 2'b01, 8'h22, "R3 dac held after load pin release");

    @(negedge clk);
    #3 clr_n = 1'b0;
    #2 check(dac_code == 32'h0, "R12 async clear", dac_code, 32'h0);
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; dac_m[i] = '0; end
    expect_dac("R12 clear held");
    clr_n = 1'b1;
    send_word(2'b10, 2'b10, 8'h00, "R12 inputs cleared (copy)");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule